// File: doc/BRIEF.md
# I2C Slave Byte Receiver with Overrun Guard

This block is a write-only I2C target for 7-bit addressing. It samples SCL and SDA with the system clock, finds START and STOP conditions, collects the address byte and compares its upper seven bits with a programmable own address. Once addressed for a write, it takes each data byte into a single holding register that software drains, and it raises an interrupt flag for every byte it accepts on the bus, the address byte included.

The acknowledge decision is tied to the state of that holding register. If the register still holds an unread byte, or if a previous overrun has not yet been cleared, the block leaves SDA released in the acknowledge slot. When the register was full, it also sets a sticky overrun flag. In either case the incoming byte is thrown away and the earlier byte is kept. Software reads the register with a one-cycle strobe and clears the interrupt and overrun flags with their own strobes.

SDA is an open-drain line: `sda_oe` high means the block pulls the line low. The line's actual level is fed back on `sda_i`.

Top module: `i2c_rx_slave`

## Requirements
- R1: After reset, and after a STOP (SDA rising while SCL high), the block is idle: clock pulses without a preceding START (SDA falling while SCL high) produce no acknowledge and change no flag.
- R2: An address byte whose bits 7..1 (first seven bits on the bus, MSB first) equal `own_addr` and whose bit 0 (eighth bit) is 0 is acknowledged when no overrun condition exists. The whole byte, including the 0 in bit 0, is loaded into the holding register. `buf_full_o` and `irq_o` are set and `rw_o` reads 0.
- R3: An address byte whose upper seven bits differ from `own_addr` gets no acknowledge. Every byte that follows it up to the next START or STOP is also ignored: no acknowledge and no change to any flag or to the holding register.
- R4: After an acknowledged write address, each data byte is shifted in MSB first on SCL rising edges and stored. It is acknowledged when no overrun condition exists.
- R5: `irq_o` is set for each byte taken in (a matched write address or a data byte, overrun or not) and falls only after a `clr_irq_i` strobe.
- R6: A `rd_buf_i` strobe clears `buf_full_o`. `rd_data_o` always shows the holding register.
- R7: A byte that completes while `buf_full_o` is 1 is not acknowledged and sets `ovf_o`. The holding register keeps its earlier contents.
- R8: `ovf_o` is sticky and falls only after a `clr_ovf_i` strobe. While it is 1, bytes are not acknowledged and are discarded, even with the holding register empty.
- R9: A matching address with bit 0 equal to 1 sets `rw_o` to 1. It is not acknowledged, does not touch the holding register, `buf_full_o` or `irq_o`, and the rest of that transfer is ignored.
- R10: `sda_oe` changes only while SCL is low. It is asserted only from the falling edge of the 8th clock of a byte to the falling edge of the 9th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| own_addr | input | 7 | Programmed 7-bit target address |
| rd_buf_i | input | 1 | Read strobe for the holding register; clears buf_full_o |
| clr_irq_i | input | 1 | Clear strobe for irq_o |
| clr_ovf_i | input | 1 | Clear strobe for ovf_o |
| rd_data_o | output | 8 | Holding register contents |
| buf_full_o | output | 1 | Holding register holds an unread byte |
| ovf_o | output | 1 | Sticky overrun flag |
| rw_o | output | 1 | Direction bit of the last matching address |
| irq_o | output | 1 | Byte-taken interrupt flag |

## Verification
The hardest state to reach from the ports is an overrun that outlives the condition that caused it. In that state the holding register has been drained but `ovf_o` is still set, so a matching address must still be refused. The stimulus gets there in steps. It lets a data byte arrive on top of the unread address byte, reads the register without clearing the overrun, and starts a new transfer. It then checks that the address gets no acknowledge and that nothing is stored. Only after `clr_ovf_i` does it expect the acknowledge to return. The acknowledge is sampled on the wired-AND bus level during the high phase of the 9th clock, so what is observed is what a master would see.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_ADDR = 2'd1,
    RX_DATA = 2'd2,
    RX_SKIP = 2'd3
  } rx_state_e;
endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d_i;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  // bus lines idle high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_rx_cond.sv
module i2c_rx_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise_o = scl_s & ~scl_q;
    scl_fall_o = ~scl_s & scl_q;
    start_o    = scl_s & scl_q & sda_q & ~sda_s;
    stop_o     = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_ok_i,
  output logic              take_o,
  output logic              rw_stb_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              sda_oe_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic              ack_q, ack_d;
  logic              oe_q, oe_d;
  logic [BYTE_W-1:0] byte_now;
  logic              addr_hit;

  assign byte_now = {shreg_q[BYTE_W-2:0], sda_s};
  assign addr_hit = (byte_now[BYTE_W-1:1] == own_addr);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    shreg_d  = shreg_q;
    ack_d    = ack_q;
    oe_d     = oe_q;
    take_o   = 1'b0;
    rw_stb_o = 1'b0;
    if (stop_det) begin
      state_d = RX_IDLE;
      cnt_d   = '0;
      ack_d   = 1'b0;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = RX_ADDR;
      cnt_d   = '0;
      ack_d   = 1'b0;
      oe_d    = 1'b0;
    end else if (state_q == RX_ADDR || state_q == RX_DATA) begin
      if (scl_rise) begin
        if (cnt_q != ACK_SLOT) begin
          shreg_d = byte_now;
          cnt_d   = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            if (state_q == RX_ADDR) begin
              ack_d = 1'b0;
              if (addr_hit) begin
                rw_stb_o = 1'b1;
                if (!byte_now[0]) begin
                  take_o = 1'b1;
                  ack_d  = ack_ok_i;
                end
              end
            end else begin
              take_o = 1'b1;
              ack_d  = ack_ok_i;
            end
          end
        end else begin
          cnt_d = '0;
          if (state_q == RX_ADDR) state_d = ack_q ? RX_DATA : RX_SKIP;
        end
      end else if (scl_fall) begin
        if (cnt_q == ACK_SLOT)   oe_d = ack_q;
        else if (cnt_q == '0)    oe_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      ack_q   <= ack_d;
      oe_q    <= oe_d;
    end
  end

  assign byte_o   = byte_now;
  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_rx_regs.sv
module i2c_rx_regs
  import i2c_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              rw_stb_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rd_buf_i,
  input  logic              clr_irq_i,
  input  logic              clr_ovf_i,
  output logic              ack_ok_o,
  output logic [BYTE_W-1:0] buf_o,
  output logic              full_o,
  output logic              ovf_o,
  output logic              rw_o,
  output logic              irq_o
);
  logic [BYTE_W-1:0] buf_q, buf_d;
  logic              full_q, full_d;
  logic              ovf_q, ovf_d;
  logic              rw_q, rw_d;
  logic              irq_q, irq_d;
  logic              blocked;

  assign blocked  = full_q | ovf_q;
  assign ack_ok_o = ~blocked;

  always_comb begin
    buf_d  = buf_q;
    full_d = full_q;
    ovf_d  = ovf_q;
    rw_d   = rw_q;
    irq_d  = irq_q;
    if (rd_buf_i)  full_d = 1'b0;
    if (clr_irq_i) irq_d  = 1'b0;
    if (clr_ovf_i) ovf_d  = 1'b0;
    if (rw_stb_i)  rw_d   = byte_i[0];
    if (take_i) begin
      irq_d = 1'b1;
      if (!blocked) begin
        buf_d  = byte_i;
        full_d = 1'b1;
      end else if (full_q) begin
        ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
      rw_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      full_q <= full_d;
      ovf_q  <= ovf_d;
      rw_q   <= rw_d;
      irq_q  <= irq_d;
    end
  end

  assign buf_o  = buf_q;
  assign full_o = full_q;
  assign ovf_o  = ovf_q;
  assign rw_o   = rw_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/i2c_rx_slave.sv
module i2c_rx_slave
  import i2c_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              rd_buf_i,
  input  logic              clr_irq_i,
  input  logic              clr_ovf_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              buf_full_o,
  output logic              ovf_o,
  output logic              rw_o,
  output logic              irq_o
);
  logic              scl_s, sda_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              ack_ok, take, rw_stb;
  logic [BYTE_W-1:0] rx_byte;

  i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s)
  );

  i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
  );

  i2c_rx_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_rx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .ack_ok_i(ack_ok),
    .take_o(take), .rw_stb_o(rw_stb), .byte_o(rx_byte),
    .sda_oe_o(sda_oe)
  );

  i2c_rx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .take_i(take), .rw_stb_i(rw_stb),
    .byte_i(rx_byte), .rd_buf_i(rd_buf_i), .clr_irq_i(clr_irq_i),
    .clr_ovf_i(clr_ovf_i), .ack_ok_o(ack_ok), .buf_o(rd_data_o),
    .full_o(buf_full_o), .ovf_o(ovf_o), .rw_o(rw_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/i2c_rx_slave_chk.sv
module i2c_rx_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       rd_buf_i,
  input logic       clr_irq_i,
  input logic       clr_ovf_i,
  input logic [7:0] rd_data_o,
  input logic       buf_full_o,
  input logic       ovf_o,
  input logic       irq_o
);
  // R10
  oe_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_i);

  // R7
  ovf_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(buf_full_o));

  // R7
  held_byte_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(buf_full_o) |-> $stable(rd_data_o));

  // R7
  no_ack_in_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> !ovf_o);

  // R6
  full_clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_full_o) |-> $past(rd_buf_i));

  // R5
  irq_clear_by_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(clr_irq_i));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_o) |-> $past(clr_ovf_i));
endmodule

bind i2c_rx_slave i2c_rx_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .rd_buf_i(rd_buf_i), .clr_irq_i(clr_irq_i), .clr_ovf_i(clr_ovf_i),
  .rd_data_o(rd_data_o), .buf_full_o(buf_full_o), .ovf_o(ovf_o),
  .irq_o(irq_o)
);

// File: tb/tb_i2c_rx_slave.sv
`timescale 1ns/1ps
module tb_i2c_rx_slave;
  localparam int H = 16;
  localparam logic [6:0] MY_ADDR = 7'h5A;

  logic       clk, rst_n;
  logic       scl_m, sda_m;
  logic       sda_oe, sda_bus;
  logic       rd_buf, clr_irq, clr_ovf;
  logic [7:0] rd_data;
  logic       buf_full, ovf, rw, irq;
  int         total, bad;
  bit         done;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_rx_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .own_addr(MY_ADDR), .rd_buf_i(rd_buf),
    .clr_irq_i(clr_irq), .clr_ovf_i(clr_ovf), .rd_data_o(rd_data),
    .buf_full_o(buf_full), .ovf_o(ovf), .rw_o(rw), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_h(H);
    sda_m = 1'b0; wait_h(H);
    scl_m = 1'b0; wait_h(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_h(H);
    scl_m = 1'b1; wait_h(H);
    sda_m = 1'b1; wait_h(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_h(H);
      scl_m = 1'b1; wait_h(H);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wait_h(H);
    scl_m = 1'b1; wait_h(H / 2);
    acked = (sda_bus == 1'b0);
    wait_h(H / 2);
    scl_m = 1'b0; wait_h(H);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; wait_h(1); s = 1'b0; wait_h(1);
  endtask

  task automatic sw_clear_all();
    pulse(rd_buf); pulse(clr_irq); pulse(clr_ovf);
  endtask

  task automatic t_reset();
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R1 reset buf_full", buf_full, 0);
    chk("R1 reset ovf", ovf, 0);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset rw", rw, 0);
  endtask

  task automatic t_write();
    logic a;
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a);
    chk("R2 addr ack", a, 1);
    chk("R2 addr in buffer", rd_data, {MY_ADDR, 1'b0});
    chk("R2 buf_full", buf_full, 1);
    chk("R2 irq", irq, 1);
    chk("R2 rw", rw, 0);
    pulse(rd_buf);
    chk("R6 read clears full", buf_full, 0);
    chk("R5 irq stays until cleared", irq, 1);
    pulse(clr_irq);
    chk("R5 irq cleared", irq, 0);
    send_byte(8'hC3, a);
    chk("R4 data ack", a, 1);
    chk("R4 data stored", rd_data, 8'hC3);
    chk("R5 irq on data", irq, 1);
    pulse(rd_buf); pulse(clr_irq);
    send_byte(8'h96, a);
    chk("R4 second data ack", a, 1);
    chk("R4 second data stored", rd_data, 8'h96);
    bus_stop();
    sw_clear_all();
  endtask

  task automatic t_overflow();
    logic a;
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a);
    chk("R2 addr ack before overrun", a, 1);
    pulse(clr_irq);
    send_byte(8'h11, a);
    chk("R7 nack when full", a, 0);
    chk("R7 ovf set", ovf, 1);
    chk("R7 old byte kept", rd_data, {MY_ADDR, 1'b0});
    chk("R5 irq on overrun byte", irq, 1);
    bus_stop();
    pulse(rd_buf); pulse(clr_irq);
    chk("R8 ovf stays after read", ovf, 1);
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a);
    chk("R8 nack while ovf", a, 0);
    chk("R8 nothing stored", buf_full, 0);
    bus_stop();
    pulse(clr_irq); pulse(clr_ovf);
    chk("R8 ovf cleared", ovf, 0);
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a);
    chk("R8 ack after clear", a, 1);
    bus_stop();
    sw_clear_all();
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start();
    send_byte({7'h23, 1'b0}, a);
    chk("R3 no ack on mismatch", a, 0);
    send_byte(8'h55, a);
    chk("R3 data ignored no ack", a, 0);
    chk("R3 irq untouched", irq, 0);
    chk("R3 buf_full untouched", buf_full, 0);
    bus_stop();
  endtask

  task automatic t_read_dir();
    logic a;
    bus_start();
    send_byte({MY_ADDR, 1'b1}, a);
    chk("R9 no ack on read", a, 0);
    chk("R9 rw set", rw, 1);
    chk("R9 irq untouched", irq, 0);
    chk("R9 buf_full untouched", buf_full, 0);
    send_byte(8'h77, a);
    chk("R9 rest ignored", a, 0);
    bus_stop();
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a);
    chk("R9 rw back to write", rw, 0);
    bus_stop();
    sw_clear_all();
  endtask

  task automatic t_after_stop();
    logic a;
    send_byte({MY_ADDR, 1'b0}, a);
    chk("R1 no ack without start", a, 0);
    chk("R1 irq untouched", irq, 0);
    chk("R1 buf_full untouched", buf_full, 0);
  endtask

  initial begin
    total = 0; bad = 0; done = 0;
    scl_m = 1'b1; sda_m = 1'b1;
    rd_buf = 0; clr_irq = 0; clr_ovf = 0;
    rst_n = 1'b0;
    wait_h(5);
    rst_n = 1'b1;
    wait_h(5);
    t_reset();
    t_write();
    t_overflow();
    t_mismatch();
    t_read_dir();
    t_after_stop();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule